// File: doc/BRIEF.md
# DMA Halt and Resume Status Control

This block holds the halted state of two bus-master DMA engines, one moving receive traffic and one moving transmit traffic. It presents that state in a 32-bit status and control word. Software stops or restarts either engine with single-cycle command strobes. The receive engine also stops on its own when the descriptor it has just fetched is already marked as finished. Each engine watches its own halt request output. That output is high exactly while the engine is marked halted, so the engine stops once its current bus transfer is done.

A third bit of the word shows, without delay, the completion-request flag of the transmit descriptor now in use. All other bits of the word are zero. Descriptor fetching, the DMA datapaths and interrupt generation sit outside this block. A descriptor-fetch strobe and its done bit stand in for the fetch logic.

Top module: `dmaHaltStatus`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it rises, `statusWord` reads 0x00000000 and both halt request outputs are 0.
- R2: A 1 on `rxHaltCmd` sets the receive halted flag (bit 0 of `statusWord`) at the next rising clock edge.
- R3: When `rxDescValid` and `rxDescDone` are both 1 in the same cycle, bit 0 is set at the next edge. If only one of the two is 1, bit 0 does not change.
- R4: A 1 on `rxResumeCmd` clears bit 0 at the next edge. With no resume, bit 0 keeps its value. A 0 on a command input has no effect.
- R5: A 1 on `txHaltCmd` sets the transmit halted flag (bit 2) at the next edge. A 1 on `txResumeCmd` clears it at the next edge. Otherwise bit 2 holds.
- R6: When a set source (the halt command, or for receive the already-done descriptor) and the resume command for the same engine are 1 in the same cycle, the flag ends up 1.
- R7: Bit 1 of `statusWord` equals `txDescIndicate` in the same cycle, with no register between them.
- R8: Bits 31 to 3 of `statusWord` always read 0.
- R9: `rxHaltReq` equals bit 0 and `txHaltReq` equals bit 2 in every cycle.
- R10: A command for one engine never changes the flag of the other engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxHaltCmd | input | 1 | Receive halt command pulse |
| rxResumeCmd | input | 1 | Receive resume command pulse |
| txHaltCmd | input | 1 | Transmit halt command pulse |
| txResumeCmd | input | 1 | Transmit resume command pulse |
| rxDescValid | input | 1 | A receive descriptor was fetched this cycle |
| rxDescDone | input | 1 | Done bit of the fetched receive descriptor |
| txDescIndicate | input | 1 | Completion-request bit of the current transmit descriptor |
| statusWord | output | 32 | Status word: bit 0 receive halted, bit 1 completion request, bit 2 transmit halted |
| rxHaltReq | output | 1 | Halt request to the receive engine |
| txHaltReq | output | 1 | Halt request to the transmit engine |

## Verification
For one engine, a set source and the resume command can arrive in the same cycle. For the receive engine the set source is either the explicit halt or an already-done descriptor. The vector table drives these collisions on purpose: halt with resume on each engine, and a done-descriptor fetch with a receive resume. After the edge the bench requires the flag to read 1. Later vectors send resume alone and check that the flag clears, so a flag that stayed stuck at 1 would also be caught.

// File: rtl/dmaHaltPkg.sv
package dmaHaltPkg;
  localparam int NUM_ENG = 2;
  localparam int ENG_RX  = 0;
  localparam int ENG_TX  = 1;
  localparam int BIT_RX_HALTED = 0;
  localparam int BIT_TX_CMPL   = 1;
  localparam int BIT_TX_HALTED = 2;

  typedef struct packed {
    logic [NUM_ENG-1:0] setFlag;
    logic [NUM_ENG-1:0] clrFlag;
  } haltStrobes_t;

  function automatic int engBit(input int eng);
    return (eng == ENG_RX) ? BIT_RX_HALTED : BIT_TX_HALTED;
  endfunction
endpackage

// File: rtl/dmaHaltCtrl.sv
module dmaHaltCtrl
  import dmaHaltPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         rxHaltCmd,
  input  logic         rxResumeCmd,
  input  logic         txHaltCmd,
  input  logic         txResumeCmd,
  input  logic         rxDescValid,
  input  logic         rxDescDone,
  output haltStrobes_t strobes
);
  logic rxImplicit;
  logic [NUM_ENG-1:0] haltIn;
  logic [NUM_ENG-1:0] resumeIn;

  assign rxImplicit = rxDescValid & rxDescDone;
  assign haltIn[ENG_RX]   = rxHaltCmd | rxImplicit;
  assign haltIn[ENG_TX]   = txHaltCmd;
  assign resumeIn[ENG_RX] = rxResumeCmd;
  assign resumeIn[ENG_TX] = txResumeCmd;

  // A set source beats a resume for the same engine
  always_comb begin
    strobes.setFlag = haltIn;
    strobes.clrFlag = resumeIn & ~haltIn;
  end

  assert_excl_strobe_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.setFlag & strobes.clrFlag) == '0);
  assert_implicit_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rxDescValid && rxDescDone) |-> strobes.setFlag[ENG_RX]);
endmodule

// File: rtl/dmaHaltData.sv
module dmaHaltData
  import dmaHaltPkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  haltStrobes_t      strobes,
  input  logic              txDescIndicate,
  output logic [WORD_W-1:0] statusWord,
  output logic [NUM_ENG-1:0] halted
);
  for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   halted[e] <= 1'b0;
      else if (strobes.setFlag[e]) halted[e] <= 1'b1;
      else if (strobes.clrFlag[e]) halted[e] <= 1'b0;
    end

    assert_flag_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
      (!strobes.setFlag[e] && !strobes.clrFlag[e]) |=> $stable(halted[e]));
    assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rstN)
      strobes.setFlag[e] |=> halted[e]);
  end

  always_comb begin
    statusWord = '0;
    statusWord[BIT_RX_HALTED] = halted[ENG_RX];
    statusWord[BIT_TX_CMPL]   = txDescIndicate;
    statusWord[BIT_TX_HALTED] = halted[ENG_TX];
  end
endmodule

// File: rtl/dmaHaltStatus.sv
module dmaHaltStatus
  import dmaHaltPkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxHaltCmd,
  input  logic              rxResumeCmd,
  input  logic              txHaltCmd,
  input  logic              txResumeCmd,
  input  logic              rxDescValid,
  input  logic              rxDescDone,
  input  logic              txDescIndicate,
  output logic [WORD_W-1:0] statusWord,
  output logic              rxHaltReq,
  output logic              txHaltReq
);
  haltStrobes_t strobes;
  logic [NUM_ENG-1:0] halted;

  dmaHaltCtrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .rxHaltCmd(rxHaltCmd), .rxResumeCmd(rxResumeCmd),
    .txHaltCmd(txHaltCmd), .txResumeCmd(txResumeCmd),
    .rxDescValid(rxDescValid), .rxDescDone(rxDescDone),
    .strobes(strobes)
  );

  dmaHaltData #(.WORD_W(WORD_W)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .txDescIndicate(txDescIndicate),
    .statusWord(statusWord), .halted(halted)
  );

  assign rxHaltReq = halted[ENG_RX];
  assign txHaltReq = halted[ENG_TX];

  assert_rx_resume_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rxResumeCmd && !rxHaltCmd && !(rxDescValid && rxDescDone)) |=> !statusWord[BIT_RX_HALTED]);
  assert_tx_halt_R5: assert property (@(posedge clk) disable iff (!rstN)
    txHaltCmd |=> statusWord[BIT_TX_HALTED]);
  assert_tx_resume_R5: assert property (@(posedge clk) disable iff (!rstN)
    (txResumeCmd && !txHaltCmd) |=> !statusWord[BIT_TX_HALTED]);
  assert_rx_isolated_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!rxHaltCmd && !rxResumeCmd && !(rxDescValid && rxDescDone)) |=> $stable(rxHaltReq));
  assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[WORD_W-1:3] == '0);
  assert_req_match_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rxHaltReq == statusWord[BIT_RX_HALTED]) && (txHaltReq == statusWord[BIT_TX_HALTED]));
endmodule

// File: tb/dmaHaltStatus_bench.sv
module dmaHaltStatus_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxHaltCmd = 0, rxResumeCmd = 0, txHaltCmd = 0, txResumeCmd = 0;
  logic rxDescValid = 0, rxDescDone = 0, txDescIndicate = 0;
  logic [31:0] statusWord;
  logic rxHaltReq, txHaltReq;
  int nChecks = 0;
  int nFails  = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dmaHaltStatus u_dmaHaltStatus (.*);

  // {rxH, rxR, txH, txR, descValid, descDone, indicate, expTx, expInd, expRx}
  localparam int NVEC = 14;
  localparam logic [9:0] VEC [NVEC] = '{
    10'b1000000_001, // R2 explicit rx halt
    10'b0000000_001, // R4 hold
    10'b0100000_000, // R4 resume
    10'b0000110_001, // R3 implicit halt
    10'b0100110_001, // R6 implicit beats resume
    10'b0100000_000, // R4 resume
    10'b0000100_000, // R3 valid only
    10'b0000010_000, // R3 done only
    10'b0010000_100, // R5 tx halt, R10 rx untouched
    10'b0000001_110, // R7 indicate
    10'b1100000_101, // R6 rx halt beats resume
    10'b0001000_001, // R5 tx resume, R10
    10'b0011000_101, // R6 tx halt beats resume
    10'b0101000_000  // R4 R5 both resume
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string req, input logic [2:0] e);
    check(req, statusWord, {29'd0, e});
    check("R8", {3'd0, statusWord[31:3]}, 32'd0);
    check("R9", {30'd0, rxHaltReq, txHaltReq}, {30'd0, statusWord[0], statusWord[2]});
  endtask

  task automatic drive(input logic [6:0] s);
    {rxHaltCmd, rxResumeCmd, txHaltCmd, txResumeCmd, rxDescValid, rxDescDone, txDescIndicate} = s;
  endtask

  initial begin
    #5;
    checkAll("R1", 3'b000);
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #5;
    checkAll("R1", 3'b000);
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      drive(VEC[i][9:3]);
      #2 check("R7", {31'd0, statusWord[1]}, {31'd0, VEC[i][3]});
      @(posedge clk); #5;
      checkAll($sformatf("vec%0d", i), VEC[i][2:0]);
    end
    // corner: indicate toggles mid-cycle without a clock edge
    @(negedge clk); drive(7'b0000001);
    #3 check("R7", {31'd0, statusWord[1]}, 32'd1);
    drive(7'b0000000);
    #3 check("R7", {31'd0, statusWord[1]}, 32'd0);
    // reset while both halted
    @(negedge clk); drive(7'b1010000);
    @(negedge clk); drive(7'b0000000);
    checkAll("R2", 3'b101);
    rstN = 1'b0;
    #2 checkAll("R1", 3'b000);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #5;
    checkAll("R1", 3'b000);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule